// File: doc/BRIEF.md
# Four-Channel Interleaved Piecewise-Cubic Evaluator

This block evaluates a fixed, smooth curve built from four cubic pieces. Each input sample is a signed 18-bit position. The two top bits of the position, taken after the sign bit is flipped, pick one of four pieces. The remaining bits form a local coordinate between -1 and +1 inside that piece. The selected cubic is then evaluated by Horner's rule, with one multiplier per Horner step and a rounding step after every product.

The pipeline accepts one sample on every clock and returns one result on every clock after a fixed delay. Up to four independent streams share it, each marked by a 2-bit channel tag. The tag travels with its sample, so the streams can be interleaved in any order. Each sample carries its own coefficient set down the pipe, so neighbouring samples may fall in different pieces without affecting each other. The coefficient set is a constant inside the block.

Top module: `spline4_pipe`

## Requirements
- R1: After reset, out_valid is 0 and out_data is 0 until the first sample arrives.
- R2: The piece index is {~in_x[17], in_x[16]}. So x in [-131072,-65537] uses piece 0, [-65536,-1] piece 1, [0,65535] piece 2, and [65536,131071] piece 3.
- R3: The local coordinate t is the signed 16-bit value {~in_x[15], in_x[14:0]}, read as t/32768 in [-1, 1).
- R4: The coefficients (c0,c1,c2,c3) are: piece 0 (10000,6000,1500,300), piece 1 (20000,9000,2000,-400), piece 2 (35000,12000,-1000,800), piece 3 (50000,16000,3000,-1200). At t=0 the output equals c0.
- R5: The output is a=c3, then a=((a*t+16384)>>>15)+c2, then a=((a*t+16384)>>>15)+c1, then a=((a*t+16384)>>>15)+c0. This is a signed 20-bit result, and a reference value may differ from it by at most 1 LSB.
- R6: A sample presented with in_valid in cycle n appears with out_valid in cycle n+4. out_valid is 0 in every other cycle. One sample is accepted per clock.
- R7: out_chan equals the in_chan that was presented with the sample.
- R8: While out_valid is 0, out_data keeps the value of the last valid result.
- R9: The end points x=-131072 (piece 0, t=-32768) and x=131071 (piece 3, t=32767) are evaluated per R5.
- R10: Back-to-back samples in different pieces each use their own piece's coefficients.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample present |
| in_chan | input | 2 | Channel tag of the input sample |
| in_x | input | 18 | Signed position to evaluate |
| out_valid | output | 1 | Result present |
| out_chan | output | 2 | Channel tag of the result |
| out_data | output | 20 | Signed curve value |

## Verification
The hardest case to reach from the ports is a pipeline that holds samples from all four pieces and all four channels at once, with bubbles between them. Only in that state does a coefficient set or tag that slips by one stage give a visible error. The stimulus runs four interleaved ramps with different step sizes, so the pieces change at different times on each channel. It inserts idle cycles at a fixed rhythm, and it adds a burst that visits all four pieces in consecutive cycles.

// File: rtl/spl_pkg.sv
package spl_pkg;
    parameter int IN_W     = 18;
    parameter int SEG_BITS = 2;
    parameter int COEF_W   = 18;
    parameter int CH_BITS  = 2;
    parameter int NCOEF    = 4;
    localparam int NSEG    = 1 << SEG_BITS;
    localparam int T_W     = IN_W - SEG_BITS;
    localparam int ACC_W   = COEF_W + 2;
    localparam int PROD_W  = ACC_W + T_W;
    localparam int LAT     = NCOEF;

    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic signed [T_W-1:0]    loc_t;
    typedef logic signed [ACC_W-1:0]  acc_t;

    typedef struct packed {
        logic                   valid;
        logic [CH_BITS-1:0]     chan;
        loc_t                   t;
        coef_t [NCOEF-2:0]      c;
        acc_t                   acc;
    } slot_t;

    // Constant per-piece coefficient set; k selects the power of t.
    function automatic coef_t coef_lut(input logic [SEG_BITS-1:0] seg, input int k);
        coef_t r;
        r = '0;
        case (int'(seg))
            0: case (k) 0: r = 18'sd10000; 1: r = 18'sd6000;  2: r = 18'sd1500;  default: r = 18'sd300;   endcase
            1: case (k) 0: r = 18'sd20000; 1: r = 18'sd9000;  2: r = 18'sd2000;  default: r = -18'sd400;  endcase
            2: case (k) 0: r = 18'sd35000; 1: r = 18'sd12000; 2: r = -18'sd1000; default: r = 18'sd800;   endcase
            3: case (k) 0: r = 18'sd50000; 1: r = 18'sd16000; 2: r = 18'sd3000;  default: r = -18'sd1200; endcase
            default: r = '0;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/spl_index.sv
module spl_index
    import spl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [CH_BITS-1:0] in_chan,
    input  logic [IN_W-1:0]    in_x,
    output slot_t              out_q
);
    slot_t                d;
    slot_t                q;
    logic [IN_W-1:0]      offset_d;
    logic [SEG_BITS-1:0]  seg_d;

    always_comb begin
        offset_d = in_x ^ (IN_W'(1) << (IN_W - 1));
        seg_d    = offset_d[IN_W-1:T_W];
        d        = q;
        d.valid  = in_valid;
        if (in_valid) begin
            d.chan = in_chan;
            d.t    = {~offset_d[T_W-1], offset_d[T_W-2:0]};
            for (int k = 0; k < NCOEF - 1; k++) begin
                d.c[k] = coef_lut(seg_d, k);
            end
            d.acc = ACC_W'(coef_lut(seg_d, NCOEF - 1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_q = q;
endmodule

// File: rtl/spl_stage.sv
module spl_stage
    import spl_pkg::*;
#(
    parameter int STEP = 0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  slot_t in_s,
    output slot_t out_q
);
    localparam int SHIFT = T_W - 1;
    localparam int HALF  = 1 << (T_W - 2);
    localparam int CIDX  = NCOEF - 2 - STEP;

    slot_t                     d;
    slot_t                     q;
    logic signed [ACC_W-1:0]   a_d;
    logic signed [T_W-1:0]     t_d;
    logic signed [PROD_W-1:0]  prod_d;
    logic signed [PROD_W-1:0]  rnd_d;

    always_comb begin
        a_d    = in_s.acc;
        t_d    = in_s.t;
        prod_d = PROD_W'(a_d) * PROD_W'(t_d);
        rnd_d  = (prod_d + PROD_W'(HALF)) >>> SHIFT;
        d       = q;
        d.valid = in_s.valid;
        if (in_s.valid) begin
            d     = in_s;
            d.acc = ACC_W'(rnd_d) + ACC_W'($signed(in_s.c[CIDX]));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_q = q;

    // R6
    step_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.valid == $past(in_s.valid));

    // R8
    hold_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_s.valid |=> q.acc == $past(q.acc));
endmodule

// File: rtl/spline4_pipe.sv
module spline4_pipe
    import spl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [CH_BITS-1:0] in_chan,
    input  logic [IN_W-1:0]    in_x,
    output logic               out_valid,
    output logic [CH_BITS-1:0] out_chan,
    output logic [ACC_W-1:0]   out_data
);
    slot_t stg [LAT];

    spl_index u_index (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_chan  (in_chan),
        .in_x     (in_x),
        .out_q    (stg[0])
    );

    for (genvar i = 0; i < NCOEF - 1; i++) begin : g_horner
        spl_stage #(.STEP(i)) u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .in_s  (stg[i]),
            .out_q (stg[i+1])
        );
    end

    assign out_valid = stg[LAT-1].valid;
    assign out_chan  = stg[LAT-1].chan;
    assign out_data  = stg[LAT-1].acc;

    // Cycles since reset, saturating at the latency, for history checks.
    logic [2:0] age_d, age_q;

    always_comb begin
        age_d = age_q;
        if (age_q != 3'(LAT)) age_d = age_q + 3'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) age_q <= '0;
        else        age_q <= age_d;
    end

    // R6
    lat_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 3'(LAT)) |-> (out_valid == $past(in_valid, LAT)));

    // R7
    chan_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 3'(LAT) && out_valid) |-> (out_chan == $past(in_chan, LAT)));
endmodule

// File: tb/spline4_pipe_bench.sv
module spline4_pipe_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_chan = '0;
    logic [17:0] in_x = '0;
    logic        out_valid;
    logic [1:0]  out_chan;
    logic [19:0] out_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;
    longint last_out = 0;

    typedef struct {
        int         due;
        logic [1:0] ch;
        longint     val;
    } exp_t;
    exp_t  q[$];
    string tq[$];

    spline4_pipe u_spline4_pipe (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan),
        .in_x(in_x), .out_valid(out_valid), .out_chan(out_chan), .out_data(out_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic longint coef(input int seg, input int k);
        int tab [4][4] = '{'{10000, 6000, 1500, 300},
                           '{20000, 9000, 2000, -400},
                           '{35000, 12000, -1000, 800},
                           '{50000, 16000, 3000, -1200}};
        return longint'(tab[seg][k]);
    endfunction

    function automatic longint ref_eval(input logic [17:0] x);
        int     seg;
        longint t;
        longint a;
        logic [15:0] tb;
        seg = int'({~x[17], x[16]});
        tb  = {~x[15], x[14:0]};
        t   = longint'($signed(tb));
        a   = coef(seg, 3);
        for (int k = 2; k >= 0; k--) a = ((a * t + 16384) >>> 15) + coef(seg, k);
        return a;
    endfunction

    task automatic check(input string req, input longint act, input longint exp, input longint tol);
        longint diff;
        checks++;
        diff = act - exp;
        if (diff < 0) diff = -diff;
        if (diff > tol) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic check_out();
        exp_t  e;
        string tag;
        if (q.size() > 0 && q[0].due == cyc) begin
            e = q.pop_front();
            tag = tq.pop_front();
            check("R6", longint'(out_valid), 1, 0);
            check("R7", longint'(out_chan), longint'(e.ch), 0);
            check(tag, longint'($signed(out_data)), e.val, 1);
            last_out = longint'($signed(out_data));
        end else begin
            check("R6", longint'(out_valid), 0, 0);
            check("R8", longint'($signed(out_data)), last_out, 0);
        end
    endtask

    task automatic step(input logic v, input logic [1:0] ch, input int x, input string tag);
        @(negedge clk);
        cyc++;
        check_out();
        in_valid = v;
        in_chan  = ch;
        in_x     = x[17:0];
        if (v) begin
            exp_t e;
            e.due = cyc + 4;
            e.ch  = ch;
            e.val = ref_eval(x[17:0]);
            q.push_back(e);
            tq.push_back(tag);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int xs [4];
        int steps [4] = '{37, 113, -59, 257};
        int bnd [8] = '{-131072, 131071, -65537, -65536, -1, 0, 65535, 65536};
        int mids [4] = '{-98304, -32768, 32768, 98304};
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", longint'(out_valid), 0, 0);
        check("R1", longint'(out_data), 0, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", longint'(out_valid), 0, 0);
        check("R1", longint'(out_data), 0, 0);

        // R9 end points, R2 piece edges, channels out of order
        for (int i = 0; i < 8; i++) step(1, 2'(3 - (i % 4)), bnd[i], (i < 2) ? "R9" : "R2");
        // R4: t = 0 in each piece yields c0
        for (int i = 0; i < 4; i++) step(1, 2'(i), mids[i], "R4");
        // R3: half-way local coordinates
        step(1, 2'd1, 16384, "R3");
        step(1, 2'd2, -16384, "R3");
        step(1, 2'd0, 81920, "R3");
        repeat (6) step(0, 2'd0, 0, "R8");

        // R10: every cycle visits a different piece
        for (int i = 0; i < 64; i++) step(1, 2'(i % 4), mids[(i * 3) % 4] + (i * 997) % 30000, "R10");

        // R5 with R7 and R8: four interleaved ramps with periodic bubbles
        xs = '{-131072, -40000, 120000, 5};
        for (int i = 0; i < 4000; i++) begin
            if (i % 50 == 49) begin
                repeat (3) step(0, 2'd0, 0, "R8");
            end
            step(1, 2'(i % 4), xs[i % 4], "R5");
            xs[i % 4] = xs[i % 4] + steps[i % 4];
            if (xs[i % 4] > 131071)  xs[i % 4] = xs[i % 4] - 262144;
            if (xs[i % 4] < -131072) xs[i % 4] = xs[i % 4] + 262144;
        end

        repeat (10) step(0, 2'd0, 0, "R8");
        check("R6", longint'(q.size()), 0, 0);
        finish_run();
    end
endmodule